// File: doc/BRIEF.md
# Power-Up EEPROM Boot Selector

This controller runs once after reset, before the rest of the device starts normal work. It reads bytes from a serial EEPROM through a byte-level request/acknowledge port and looks at the byte stored at EEPROM address 0. That signature byte picks one of three boot paths. On 0xC0 the vendor, product and device identifiers are read from the EEPROM. On 0xC2 the identifiers are read and then a code image is copied into internal RAM through a write port. On any other byte, or when no EEPROM answers, the built-in identifiers stay in force.

The bit-level serial master sits outside this block. It presents each EEPROM byte as an acknowledge pulse with data, or as a no-device pulse. The selector's outputs are the three identifier words, a single-cycle RAM write strobe with its address and data, a two-bit boot-mode code, a sticky load-error flag and a done flag. Other logic holds off normal operation until the done flag is high.

The code image is a list of records. Each record carries a length word, a start address and then the data bytes. Words are stored low byte first. A record is written only when its whole span lies inside one of the two RAM windows that may be boot-loaded. Any other record is read through and discarded.

Top module: `boot_selector`

## Requirements
- R1: While reset is held: `boot_done` and `load_err` are 0, `boot_mode` is 0, the identifiers hold their defaults (vendor 0x04B4, product 0x8613, device taken from a parameter, 0x0004 by default), `ram_we` is 0, and a request for EEPROM address 0 is presented.
- R2: `ee_req` and an unchanged `ee_addr` are held until `ee_ack` or `ee_nodev` arrives. Accepted bytes are read at consecutive addresses starting at 0.
- R3: Signature 0xC0 sets `boot_mode` to 1. Bytes 1..6 give vendor, product and device, each low byte first. Reading stops after byte 6, with no RAM writes.
- R4: Signature 0xC2 sets `boot_mode` to 2. The identifiers are loaded as in R3, byte 7 is a configuration byte that is consumed, and records start at byte 8.
- R5: A record is the length low byte, the length high byte, the start address low byte, the start address high byte, and then the data bytes. Each data byte i of an accepted record gives one `ram_we` pulse with `ram_addr` = start + i, one cycle after that byte's acknowledge.
- R6: A length high byte with bit 7 set ends the load, and `boot_done` rises.
- R7: A record is written only if all of start..start+len-1 lies within 0x0000–0x1FFF or within 0xE000–0xE1FF. Any other non-empty record has its data bytes consumed without a write and sets the sticky `load_err`.
- R8: A no-device response to the signature read, or any signature other than 0xC0 or 0xC2, gives `boot_mode` 0, default identifiers and `boot_done`, with no further reads.
- R9: A no-device response after the signature ends the boot, sets `load_err` and keeps the `boot_mode` already chosen.
- R10: Once `boot_done` is high it stays high until reset. No request is issued and the identifiers, `boot_mode` and the RAM port no longer change.
- R11: A record with length 0 writes nothing, does not set `load_err`, and is followed directly by the next record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ee_req | output | 1 | Byte read request to the serial master |
| ee_addr | output | EE_AW | EEPROM byte address of the request |
| ee_ack | input | 1 | One-cycle pulse: `ee_data` is valid |
| ee_nodev | input | 1 | One-cycle pulse: no device answered |
| ee_data | input | 8 | Byte returned with `ee_ack` |
| ram_we | output | 1 | RAM write strobe, one cycle per byte |
| ram_addr | output | 16 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| id_vendor | output | 16 | Selected vendor identifier |
| id_product | output | 16 | Selected product identifier |
| id_device | output | 16 | Selected device release identifier |
| boot_mode | output | 2 | 0 default, 1 identifiers only, 2 code load |
| boot_done | output | 1 | Boot selection complete, sticky |
| load_err | output | 1 | Sticky: a record was rejected or the EEPROM vanished |

## Verification
A table of signature cases runs the selector over 0xC0, 0xC2 with an immediate end marker, three foreign signature bytes and a silent EEPROM. These cases separate the two EEPROM paths from the fallback and from each other by the mode, the identifiers and the number of reads. A full code image then mixes an in-range record, an empty record, a record wholly outside both windows, one that ends exactly on the scratch window's last byte, and one that straddles the top of main RAM. This image shows that rejection uses the whole span and is not decided by the start address alone. A clean image confirms that `load_err` stays low without a bad record. A device that vanishes in the middle of the identifiers exercises the late no-device path.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

    typedef enum logic [3:0] {
        ST_SIG,
        ST_IDS,
        ST_CFG,
        ST_LLO,
        ST_LHI,
        ST_ALO,
        ST_AHI,
        ST_DAT,
        ST_END
    } bs_state_e;

    typedef enum logic [1:0] {
        BM_DEFAULT   = 2'd0,
        BM_IDONLY    = 2'd1,
        BM_CODELOAD  = 2'd2
    } bs_mode_e;

    localparam logic [7:0] SIG_ID_ONLY   = 8'hC0;
    localparam logic [7:0] SIG_CODE_LOAD = 8'hC2;
    localparam int         LEN_W         = 15;

endpackage

// File: rtl/boot_sig_decode.sv
module boot_sig_decode
    import boot_sel_pkg::*;
(
    input  logic [7:0] sig_byte,
    output bs_mode_e   mode
);
    always_comb begin
        unique case (sig_byte)
            SIG_ID_ONLY:   mode = BM_IDONLY;
            SIG_CODE_LOAD: mode = BM_CODELOAD;
            default:       mode = BM_DEFAULT;
        endcase
    end
endmodule

// File: rtl/boot_region_win.sv
module boot_region_win #(
    parameter logic [15:0] LO    = 16'h0000,
    parameter logic [15:0] HI    = 16'h1FFF,
    parameter int          LEN_W = 15
) (
    input  logic [15:0]      start_addr,
    input  logic [LEN_W-1:0] rec_len,
    output logic             fits
);
    localparam logic [16:0] SPAN = {1'b0, HI} - {1'b0, LO} + 17'd1;

    logic [16:0] off;
    logic [16:0] reach;

    always_comb begin
        off   = {1'b0, start_addr} - {1'b0, LO};
        reach = {1'b0, off[15:0]} + 17'(rec_len);
        fits  = !off[16] && (rec_len != '0) && (reach <= SPAN);
    end
endmodule

// File: rtl/boot_region_chk.sv
module boot_region_chk #(
    parameter logic [15:0] MAIN_LO = 16'h0000,
    parameter logic [15:0] MAIN_HI = 16'h1FFF,
    parameter logic [15:0] SCR_LO  = 16'hE000,
    parameter logic [15:0] SCR_HI  = 16'hE1FF,
    parameter int          LEN_W   = 15
) (
    input  logic [15:0]      start_addr,
    input  logic [LEN_W-1:0] rec_len,
    output logic             in_window
);
    logic fit_main;
    logic fit_scr;

    boot_region_win #(.LO(MAIN_LO), .HI(MAIN_HI), .LEN_W(LEN_W)) u_main (
        .start_addr (start_addr),
        .rec_len    (rec_len),
        .fits       (fit_main)
    );

    boot_region_win #(.LO(SCR_LO), .HI(SCR_HI), .LEN_W(LEN_W)) u_scr (
        .start_addr (start_addr),
        .rec_len    (rec_len),
        .fits       (fit_scr)
    );

    assign in_window = fit_main || fit_scr;
endmodule

// File: rtl/boot_selector.sv
module boot_selector
    import boot_sel_pkg::*;
#(
    parameter int          EE_AW   = 16,
    parameter logic [15:0] DEF_VID = 16'h04B4,
    parameter logic [15:0] DEF_PID = 16'h8613,
    parameter logic [15:0] DEF_DID = 16'h0004,
    parameter logic [15:0] MAIN_LO = 16'h0000,
    parameter logic [15:0] MAIN_HI = 16'h1FFF,
    parameter logic [15:0] SCR_LO  = 16'hE000,
    parameter logic [15:0] SCR_HI  = 16'hE1FF
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             ee_req,
    output logic [EE_AW-1:0] ee_addr,
    input  logic             ee_ack,
    input  logic             ee_nodev,
    input  logic [7:0]       ee_data,
    output logic             ram_we,
    output logic [15:0]      ram_addr,
    output logic [7:0]       ram_wdata,
    output logic [15:0]      id_vendor,
    output logic [15:0]      id_product,
    output logic [15:0]      id_device,
    output logic [1:0]       boot_mode,
    output logic             boot_done,
    output logic             load_err
);

    localparam logic [2:0] LAST_ID_IDX = 3'd6;

    typedef struct packed {
        bs_state_e        st;
        logic [EE_AW-1:0] ptr;
        logic [15:0]      vid;
        logic [15:0]      pid;
        logic [15:0]      did;
        bs_mode_e         mode;
        logic [LEN_W-1:0] len;
        logic [15:0]      wa;
        logic             wr_ok;
        logic             err;
        logic             done;
        logic             we;
        logic [15:0]      waddr;
        logic [7:0]       wdata;
    } bs_regs_t;

    bs_regs_t r_q, r_d;

    logic [15:0] rec_start;
    logic        rec_ok;
    bs_mode_e    sig_mode;

    assign rec_start = {ee_data, r_q.wa[7:0]};

    boot_region_chk #(
        .MAIN_LO (MAIN_LO), .MAIN_HI (MAIN_HI),
        .SCR_LO  (SCR_LO),  .SCR_HI  (SCR_HI),
        .LEN_W   (LEN_W)
    ) u_rchk (
        .start_addr (rec_start),
        .rec_len    (r_q.len),
        .in_window  (rec_ok)
    );

    boot_sig_decode u_sig (
        .sig_byte (ee_data),
        .mode     (sig_mode)
    );

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        if (r_q.st != ST_END) begin
            if (ee_nodev) begin
                r_d.st   = ST_END;
                r_d.done = 1'b1;
                if (r_q.st != ST_SIG) r_d.err = 1'b1;
            end else if (ee_ack) begin
                r_d.ptr = r_q.ptr + 1'b1;
                unique case (r_q.st)
                    ST_SIG: begin
                        r_d.mode = sig_mode;
                        if (sig_mode == BM_DEFAULT) begin
                            r_d.st   = ST_END;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.st = ST_IDS;
                        end
                    end
                    ST_IDS: begin
                        unique case (r_q.ptr[2:0])
                            3'd1:    r_d.vid[7:0]  = ee_data;
                            3'd2:    r_d.vid[15:8] = ee_data;
                            3'd3:    r_d.pid[7:0]  = ee_data;
                            3'd4:    r_d.pid[15:8] = ee_data;
                            3'd5:    r_d.did[7:0]  = ee_data;
                            3'd6:    r_d.did[15:8] = ee_data;
                            default: ;
                        endcase
                        if (r_q.ptr[2:0] == LAST_ID_IDX) begin
                            if (r_q.mode == BM_CODELOAD) begin
                                r_d.st = ST_CFG;
                            end else begin
                                r_d.st   = ST_END;
                                r_d.done = 1'b1;
                            end
                        end
                    end
                    ST_CFG: r_d.st = ST_LLO;
                    ST_LLO: begin
                        r_d.len[7:0] = ee_data;
                        r_d.st       = ST_LHI;
                    end
                    ST_LHI: begin
                        if (ee_data[7]) begin
                            r_d.st   = ST_END;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.len[LEN_W-1:8] = ee_data[6:0];
                            r_d.st             = ST_ALO;
                        end
                    end
                    ST_ALO: begin
                        r_d.wa[7:0] = ee_data;
                        r_d.st      = ST_AHI;
                    end
                    ST_AHI: begin
                        r_d.wa    = rec_start;
                        r_d.wr_ok = rec_ok;
                        if (r_q.len == '0) begin
                            r_d.st = ST_LLO;
                        end else begin
                            r_d.st = ST_DAT;
                            if (!rec_ok) r_d.err = 1'b1;
                        end
                    end
                    ST_DAT: begin
                        if (r_q.wr_ok) begin
                            r_d.we    = 1'b1;
                            r_d.waddr = r_q.wa;
                            r_d.wdata = ee_data;
                        end
                        r_d.wa  = r_q.wa + 16'd1;
                        r_d.len = r_q.len - 1'b1;
                        if (r_q.len == LEN_W'(1)) r_d.st = ST_LLO;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_SIG;
            r_q.mode  <= BM_DEFAULT;
            r_q.vid   <= DEF_VID;
            r_q.pid   <= DEF_PID;
            r_q.did   <= DEF_DID;
        end else begin
            r_q <= r_d;
        end
    end

    assign ee_req     = (r_q.st != ST_END);
    assign ee_addr    = r_q.ptr;
    assign ram_we     = r_q.we;
    assign ram_addr   = r_q.waddr;
    assign ram_wdata  = r_q.wdata;
    assign id_vendor  = r_q.vid;
    assign id_product = r_q.pid;
    assign id_device  = r_q.did;
    assign boot_mode  = r_q.mode;
    assign boot_done  = r_q.done;
    assign load_err   = r_q.err;

endmodule

// File: rtl/boot_selector_chk.sv
module boot_selector_chk #(
    parameter int          EE_AW   = 16,
    parameter logic [15:0] DEF_VID = 16'h04B4,
    parameter logic [15:0] DEF_PID = 16'h8613,
    parameter logic [15:0] DEF_DID = 16'h0004,
    parameter logic [15:0] MAIN_LO = 16'h0000,
    parameter logic [15:0] MAIN_HI = 16'h1FFF,
    parameter logic [15:0] SCR_LO  = 16'hE000,
    parameter logic [15:0] SCR_HI  = 16'hE1FF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ee_req,
    input logic [EE_AW-1:0] ee_addr,
    input logic             ee_ack,
    input logic             ee_nodev,
    input logic             ram_we,
    input logic [15:0]      ram_addr,
    input logic [15:0]      id_vendor,
    input logic [15:0]      id_product,
    input logic [15:0]      id_device,
    input logic [1:0]       boot_mode,
    input logic             boot_done
);
    localparam logic [15:0] MAIN_SPAN = MAIN_HI - MAIN_LO;
    localparam logic [15:0] SCR_SPAN  = SCR_HI - SCR_LO;

    logic [15:0] main_off;
    logic [15:0] scr_off;
    assign main_off = ram_addr - MAIN_LO;
    assign scr_off  = ram_addr - SCR_LO;

    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_ack && !ee_nodev) |=> (ee_req && $stable(ee_addr)));

    a_r5_write_only_codeload: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (boot_mode == 2'd2));

    a_r7_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ((main_off <= MAIN_SPAN) || (scr_off <= SCR_SPAN)));

    a_r8_default_ids: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && boot_mode == 2'd0) |->
            (id_vendor == DEF_VID && id_product == DEF_PID && id_device == DEF_DID));

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);

    a_r10_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |-> !ee_req);

    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> ($stable(id_vendor) && $stable(id_product) && $stable(id_device)
                       && $stable(boot_mode) && !ram_we));
endmodule

bind boot_selector boot_selector_chk #(
    .EE_AW   (EE_AW),
    .DEF_VID (DEF_VID), .DEF_PID (DEF_PID), .DEF_DID (DEF_DID),
    .MAIN_LO (MAIN_LO), .MAIN_HI (MAIN_HI),
    .SCR_LO  (SCR_LO),  .SCR_HI  (SCR_HI)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ee_req     (ee_req),
    .ee_addr    (ee_addr),
    .ee_ack     (ee_ack),
    .ee_nodev   (ee_nodev),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .id_vendor  (id_vendor),
    .id_product (id_product),
    .id_device  (id_device),
    .boot_mode  (boot_mode),
    .boot_done  (boot_done)
);

// File: tb/boot_selector_tb.sv
`timescale 1ns/1ps
module boot_selector_tb;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ee_req;
    logic [15:0] ee_addr;
    logic        ee_ack = 1'b0;
    logic        ee_nodev = 1'b0;
    logic [7:0]  ee_data = 8'h00;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [15:0] id_vendor, id_product, id_device;
    logic [1:0]  boot_mode;
    logic        boot_done, load_err;

    always #4 clk = ~clk;

    boot_selector u_dut (
        .clk (clk), .rst_n (rst_n),
        .ee_req (ee_req), .ee_addr (ee_addr), .ee_ack (ee_ack),
        .ee_nodev (ee_nodev), .ee_data (ee_data),
        .ram_we (ram_we), .ram_addr (ram_addr), .ram_wdata (ram_wdata),
        .id_vendor (id_vendor), .id_product (id_product), .id_device (id_device),
        .boot_mode (boot_mode), .boot_done (boot_done), .load_err (load_err)
    );

    logic [7:0]  ee [0:63];
    int          nodev_from = -1;
    int          resp_cnt, seq_bad, wr_cnt, lat_cnt, exp_addr;
    logic [15:0] wa_log [0:15];
    logic [7:0]  wd_log [0:15];
    int          n_chk = 0;
    int          n_bad = 0;

    // EEPROM responder and write logger, all on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            ee_ack   = 1'b0;
            ee_nodev = 1'b0;
            if (!rst_n) begin
                resp_cnt = 0; seq_bad = 0; wr_cnt = 0; lat_cnt = 0; exp_addr = 0;
            end else begin
                if (ram_we && wr_cnt < 16) begin
                    wa_log[wr_cnt] = ram_addr;
                    wd_log[wr_cnt] = ram_wdata;
                end
                if (ram_we) wr_cnt++;
                if (ee_req) begin
                    if (lat_cnt == LAT) begin
                        lat_cnt = 0;
                        if (int'(ee_addr) != exp_addr) seq_bad++;
                        if (nodev_from >= 0 && int'(ee_addr) >= nodev_from) begin
                            ee_nodev = 1'b1;
                        end else begin
                            ee_ack  = 1'b1;
                            ee_data = ee[ee_addr[5:0]];
                            resp_cnt++;
                            exp_addr++;
                        end
                    end else begin
                        lat_cnt++;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 64; i++) ee[i] = 8'h00;
    endtask

    task automatic put_ids(input logic [7:0] sig);
        ee[0] = sig;
        ee[1] = 8'h34; ee[2] = 8'h12;
        ee[3] = 8'h78; ee[4] = 8'h56;
        ee[5] = 8'hBC; ee[6] = 8'h9A;
        ee[7] = 8'h01;
    endtask

    task automatic run_boot();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            if (boot_done) break;
        end
        repeat (4) @(negedge clk);
    endtask

    // [18:11] signature, [10] silent EEPROM, [9:8] expected mode, [7:0] expected reads
    localparam logic [18:0] VEC [6] = '{
        {8'hC0, 1'b0, 2'd1, 8'd7},
        {8'hC2, 1'b0, 2'd2, 8'd10},
        {8'h00, 1'b0, 2'd0, 8'd1},
        {8'hFF, 1'b0, 2'd0, 8'd1},
        {8'hC1, 1'b0, 2'd0, 8'd1},
        {8'hC2, 1'b1, 2'd0, 8'd0}
    };

    localparam logic [47:0] DEF_IDS = {16'h04B4, 16'h8613, 16'h0004};
    localparam logic [47:0] EE_IDS  = {16'h1234, 16'h5678, 16'h9ABC};

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        clear_img();
        repeat (3) @(negedge clk);
        chk("R1 done/err/mode/we", {boot_done, load_err, boot_mode, ram_we}, 64'h0);
        chk("R1 default ids", {id_vendor, id_product, id_device}, DEF_IDS);
        chk("R1 request addr0", {ee_req, ee_addr}, {1'b1, 16'h0000});

        // Signature table: R3, R4, R6, R8
        for (int v = 0; v < 6; v++) begin
            logic [18:0] e;
            e = VEC[v];
            clear_img();
            put_ids(e[18:11]);
            ee[8] = 8'h00; ee[9] = 8'h80;
            nodev_from = e[10] ? 0 : -1;
            run_boot();
            chk("R3/R4/R8 mode", boot_mode, e[9:8]);
            chk("R3/R4/R8 ids", {id_vendor, id_product, id_device},
                (e[9:8] == 2'd0) ? DEF_IDS : EE_IDS);
            chk("R6/R8 done, no error", {boot_done, load_err}, 2'b10);
            chk("R3 reads accepted", resp_cnt, e[7:0]);
            chk("R3 no ram writes", wr_cnt, 0);
            chk("R2 sequential addr", seq_bad, 0);
        end

        // Full image: R5, R7, R11, R10
        clear_img();
        put_ids(8'hC2);
        begin
            logic [7:0] img [31];
            img = '{8'h03,8'h00,8'h00,8'h01,8'hAA,8'hBB,8'hCC,
                    8'h00,8'h00,8'h50,8'h00,
                    8'h02,8'h00,8'h00,8'h20,8'h11,8'h22,
                    8'h02,8'h00,8'hFE,8'hE1,8'h33,8'h44,
                    8'h02,8'h00,8'hFF,8'h1F,8'h55,8'h66,
                    8'h00,8'h80};
            for (int i = 0; i < 31; i++) ee[8+i] = img[i];
        end
        nodev_from = -1;
        run_boot();
        chk("R4 mode code load", boot_mode, 2'd2);
        chk("R5 write count", wr_cnt, 5);
        chk("R5 write0", {wa_log[0], wd_log[0]}, {16'h0100, 8'hAA});
        chk("R5 write2", {wa_log[2], wd_log[2]}, {16'h0102, 8'hCC});
        chk("R7 scratch edge write", {wa_log[3], wd_log[3], wa_log[4], wd_log[4]},
            {16'hE1FE, 8'h33, 16'hE1FF, 8'h44});
        chk("R7 sticky error", load_err, 1'b1);
        chk("R6 reads to end marker", resp_cnt, 39);
        chk("R2 sequential addr", seq_bad, 0);
        begin
            logic [52:0] snap;
            int          rc;
            snap = {id_vendor, id_product, id_device, boot_mode, boot_done, load_err, ram_we};
            rc   = resp_cnt;
            repeat (20) @(negedge clk);
            chk("R10 outputs frozen", {id_vendor, id_product, id_device, boot_mode,
                boot_done, load_err, ram_we}, snap);
            chk("R10 no reads after done", {ee_req, 32'(resp_cnt)}, {1'b0, 32'(rc)});
        end

        // Clean image with empty record: R11
        clear_img();
        put_ids(8'hC2);
        ee[8] = 8'h00; ee[9] = 8'h00; ee[10] = 8'h34; ee[11] = 8'h12;
        ee[12] = 8'h01; ee[13] = 8'h00; ee[14] = 8'h00; ee[15] = 8'hE0; ee[16] = 8'h5A;
        ee[17] = 8'hFF; ee[18] = 8'hFF;
        run_boot();
        chk("R11 no error", load_err, 1'b0);
        chk("R11 single write", {32'(wr_cnt), wa_log[0], wd_log[0]}, {32'd1, 16'hE000, 8'h5A});
        chk("R11 reads", resp_cnt, 19);

        // Device vanishes mid identifiers: R9
        clear_img();
        put_ids(8'hC0);
        nodev_from = 3;
        run_boot();
        chk("R9 mode kept", boot_mode, 2'd1);
        chk("R9 done and error", {boot_done, load_err}, 2'b11);
        chk("R9 partial ids", {id_vendor, id_product}, {16'h1234, 16'h8613});
        chk("R9 reads", resp_cnt, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule